// File: doc/BRIEF.md
# Serial Clock/Control Register Slave with Write Unlock

This block is a two-wire serial slave that exposes a small array of clock and control registers to a bus master. A transaction opens with a start condition and a device address byte, followed for writes by a two-byte word address and one data byte. Reads can continue from an internal register pointer (current-address read). They can also follow a dummy write that only loads the pointer, closed by a repeated start and a read address byte (random read). SDA is open-drain and is modelled as an output enable that pulls the line low. The register storage lives outside the block and is reached through a simple register-file port.

Register writes are gated. Only the status register can be written freely. Any other register accepts data only after the status register has received 02h and then 06h in two separate transactions. Every write that is accepted is followed by a busy window that models a nonvolatile write cycle. During that window the slave ignores the bus completely and leaves SDA released.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: The slave acknowledges only the device address byte whose upper seven bits are 1101111 (bit 0 is R/W, 1 = read, so 0xDE writes and 0xDF reads); any other address byte is not acknowledged and SDA stays released.
- R2: A write carries a 16-bit word address sent high byte first, then one data byte; the slave acknowledges the address byte, both word-address bytes and the data byte. The register index is the low log2(REGS) bits of the word address, and the higher bits are ignored.
- R3: After reset the register pointer is 0, so a current-address read returns register 0.
- R4: A random read (a dummy write of the word address, a repeated start, then the read address byte) returns the register at that word address.
- R5: Each transferred data byte advances the pointer by one, wrapping from REGS-1 to 0. A read continues byte after byte while the master acknowledges and ends at the master's NACK.
- R6: A write to a register other than the status register (word address 003Fh) takes effect only when unlocked. Unlocking needs a status write of 02h and then a status write of 06h. A status write of 02h always moves to the half-unlocked step; any other status value, or 06h without a preceding 02h, locks again. Status writes themselves are always accepted.
- R7: After an accepted write, the slave ignores all traffic for WCYC clock cycles, acknowledges nothing and keeps SDA released.
- R8: A start or stop condition inside a byte aborts the transfer. A write aborted before its data byte completes is not performed, and the slave then answers a new transaction normally.
- R9: The register write happens at the stop condition that follows the data byte, as a single-cycle rf_wr pulse, and not at the data acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rf_addr | output | AW | Register index for read data and for writes |
| rf_wr | output | 1 | Single-cycle register write strobe |
| rf_wdata | output | 8 | Register write data |
| rf_rdata | input | 8 | Register read data for rf_addr, combinational |

## Verification
The assertions assume that SCL and SDA are glitch-free and change only well apart relative to the system clock. In particular, SDA never changes in the same synchronised sample as an SCL edge, so a data change cannot be taken for a start or stop condition. They also assume that register read data is valid in the same cycle as rf_addr. The bench drives both lines from the falling clock edge, holds each SCL phase for eight system clocks, and moves SDA four clocks away from any SCL edge. Its register model returns data for rf_addr combinationally.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_WAHI, PH_WALO, PH_WDAT, PH_RDAT
  } ph_t;

  typedef enum logic [1:0] {
    LK_SHUT, LK_HALF, LK_OPEN
  } lk_t;

  localparam logic [6:0] DEV_ID   = 7'b1101111;
  localparam logic [7:0] KEY_ONE  = 8'h02;
  localparam logic [7:0] KEY_TWO  = 8'h06;
endpackage

// File: rtl/ctl_i2c_pinsync.sv
module ctl_i2c_pinsync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_raw, st1, st2, last;

  assign pin_raw = {sda_i, scl_i};

  // two-flop synchronisers plus one history stage; idle bus is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1  <= '1;
      st2  <= '1;
      last <= '1;
    end else begin
      st1  <= pin_raw;
      st2  <= st1;
      last <= st2;
    end
  end

  assign scl_s    = st2[0];
  assign sda_s    = st2[1];
  assign scl_rise =  st2[0] & ~last[0];
  assign scl_fall = ~st2[0] &  last[0];
  assign start_ev =  st2[0] &  last[0] &  last[1] & ~st2[1];
  assign stop_ev  =  st2[0] &  last[0] & ~last[1] &  st2[1];
endmodule

// File: rtl/ctl_i2c_unlock.sv
module ctl_i2c_unlock
  import ctl_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_wr,
  input  logic [7:0] stat_data,
  output logic       unlocked
);
  lk_t lk_q, lk_d;

  always_comb begin
    lk_d = lk_q;
    if (stat_wr) begin
      if (stat_data == KEY_ONE)                        lk_d = LK_HALF;
      else if (stat_data == KEY_TWO && lk_q == LK_HALF) lk_d = LK_OPEN;
      else                                             lk_d = LK_SHUT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lk_q <= LK_SHUT;
    else if (stat_wr) lk_q <= lk_d;
  end

  assign unlocked = (lk_q == LK_OPEN);

  // R6: the open state is only entered from the half step by the second key
  assert_unlock_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(stat_wr && stat_data == KEY_TWO && lk_q == LK_HALF));
endmodule

// File: rtl/ctl_i2c_wrtimer.sv
module ctl_i2c_wrtimer #(
  parameter  int WCYC = 64,
  localparam int CW   = $clog2(WCYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (go)               cnt_d = CW'(WCYC);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R7: an accepted write always opens the busy window on the next cycle
  assert_busy_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
endmodule

// File: rtl/ctlreg_i2c_slave.sv
module ctlreg_i2c_slave
  import ctl_i2c_pkg::*;
#(
  parameter  int REGS      = 64,
  parameter  int WCYC      = 64,
  parameter  int STAT_ADDR = 63,
  localparam int AW        = $clog2(REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] rf_addr,
  output logic          rf_wr,
  output logic [7:0]    rf_wdata,
  input  logic [7:0]    rf_rdata
);
  localparam logic [AW-1:0] STAT_IX = AW'(STAT_ADDR);

  logic [1:0] rst_pipe;
  logic       rst_s;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       busy, unlocked, commit, stat_wr;

  ph_t           ph_q, ph_d;
  logic [3:0]    bcnt_q, bcnt_d;
  logic          ackph_q, ackph_d, oe_q, oe_d;
  logic [7:0]    sh_q, sh_d, tx_q, tx_d, whi_q, whi_d, wdat_q, wdat_d;
  logic [AW-1:0] ptr_q, ptr_d, waddr_q, waddr_d;
  logic          pend_q, pend_d, mack_q, mack_d, rdm_q, rdm_d, wr_q;
  logic [15:0]   word_ad;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  ctl_i2c_pinsync u_sync (
    .clk(clk), .rst_n(rst_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign stat_wr = commit && (waddr_q == STAT_IX);

  ctl_i2c_unlock u_lock (
    .clk(clk), .rst_n(rst_s), .stat_wr(stat_wr), .stat_data(wdat_q),
    .unlocked(unlocked)
  );

  ctl_i2c_wrtimer #(.WCYC(WCYC)) u_timer (
    .clk(clk), .rst_n(rst_s), .go(commit), .busy(busy)
  );

  assign word_ad = {whi_q, sh_q};

  always_comb begin
    ph_d = ph_q;  bcnt_d = bcnt_q;  ackph_d = ackph_q;  oe_d = oe_q;
    sh_d = sh_q;  tx_d = tx_q;      whi_d = whi_q;      wdat_d = wdat_q;
    ptr_d = ptr_q; waddr_d = waddr_q; pend_d = pend_q;
    mack_d = mack_q; rdm_d = rdm_q;
    commit = 1'b0;
    if (busy) begin
      ph_d = PH_IDLE; oe_d = 1'b0; ackph_d = 1'b0; pend_d = 1'b0;
    end else if (start_ev) begin
      ph_d = PH_DEV; bcnt_d = '0; ackph_d = 1'b0; oe_d = 1'b0; pend_d = 1'b0;
    end else if (stop_ev) begin
      ph_d = PH_IDLE; oe_d = 1'b0; ackph_d = 1'b0; pend_d = 1'b0;
      commit = pend_q && (waddr_q == STAT_IX || unlocked);
    end else if (ph_q != PH_IDLE) begin
      if (scl_rise) begin
        if (!ackph_q) begin
          sh_d   = {sh_q[6:0], sda_s};
          bcnt_d = bcnt_q + 1'b1;
        end else if (ph_q == PH_RDAT) begin
          mack_d = ~sda_s;
        end
      end
      if (scl_fall) begin
        if (ackph_q) begin
          ackph_d = 1'b0; bcnt_d = '0; oe_d = 1'b0;
          case (ph_q)
            PH_DEV:  if (rdm_q) begin
                       ph_d = PH_RDAT; tx_d = rf_rdata; oe_d = ~rf_rdata[7];
                     end else ph_d = PH_WAHI;
            PH_WAHI: ph_d = PH_WALO;
            PH_WALO: ph_d = PH_WDAT;
            PH_RDAT: if (mack_q) begin
                       tx_d = rf_rdata; oe_d = ~rf_rdata[7];
                     end else ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
          endcase
        end else if (bcnt_q == 4'd8) begin
          ackph_d = 1'b1;
          case (ph_q)
            PH_DEV:  if (sh_q[7:1] == DEV_ID) begin
                       oe_d = 1'b1; rdm_d = sh_q[0];
                     end else begin
                       ph_d = PH_IDLE; ackph_d = 1'b0;
                     end
            PH_WAHI: begin oe_d = 1'b1; whi_d = sh_q; end
            PH_WALO: begin oe_d = 1'b1; ptr_d = word_ad[AW-1:0]; end
            PH_WDAT: begin
                       oe_d = 1'b1; wdat_d = sh_q; waddr_d = ptr_q;
                       ptr_d = ptr_q + 1'b1; pend_d = 1'b1;
                     end
            PH_RDAT: begin oe_d = 1'b0; ptr_d = ptr_q + 1'b1; end
            default: ph_d = PH_IDLE;
          endcase
        end else if (ph_q == PH_RDAT) begin
          oe_d = ~tx_q[6];
          tx_d = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ph_q <= PH_IDLE; bcnt_q <= '0; ackph_q <= 1'b0; oe_q <= 1'b0;
      sh_q <= '0; tx_q <= '0; whi_q <= '0; wdat_q <= '0;
      ptr_q <= '0; waddr_q <= '0; pend_q <= 1'b0; mack_q <= 1'b0;
      rdm_q <= 1'b0; wr_q <= 1'b0;
    end else begin
      ph_q <= ph_d; bcnt_q <= bcnt_d; ackph_q <= ackph_d; oe_q <= oe_d;
      sh_q <= sh_d; tx_q <= tx_d; whi_q <= whi_d; wdat_q <= wdat_d;
      ptr_q <= ptr_d; waddr_q <= waddr_d; pend_q <= pend_d; mack_q <= mack_d;
      rdm_q <= rdm_d; wr_q <= commit;
    end
  end

  assign sda_oe   = oe_q;
  assign rf_wr    = wr_q;
  assign rf_wdata = wdat_q;
  assign rf_addr  = wr_q ? waddr_q : ptr_q;

  // R7: SDA is never pulled while the write cycle runs
  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_s)
    busy |-> !sda_oe);
  // R6: only the status register is written while locked
  assert_write_gate_R6: assert property (@(posedge clk) disable iff (!rst_s)
    rf_wr |-> (rf_addr == STAT_IX || unlocked));
  // R9: the write strobe lasts exactly one cycle
  assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_s)
    rf_wr |=> !rf_wr);
  // R9: a write strobe only follows a detected stop condition
  assert_wr_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_s)
    rf_wr |-> $past(stop_ev));
endmodule

// File: tb/ctlreg_i2c_slave_tb.sv
module ctlreg_i2c_slave_tb;
  localparam int REGS = 64;
  localparam int AW   = 6;
  localparam int WCYC = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl_m = 1'b1, sda_m = 1'b1;
  logic          sda_oe, rf_wr, line;
  logic [AW-1:0] rf_addr;
  logic [7:0]    rf_wdata, rf_rdata;
  logic [7:0]    mem [REGS];
  int            nrun = 0, nfail = 0, wcnt = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  assign line = sda_m & ~sda_oe;

  ctlreg_i2c_slave #(.REGS(REGS), .WCYC(WCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .sda_oe(sda_oe),
    .rf_addr(rf_addr), .rf_wr(rf_wr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  function automatic logic [7:0] init_v(int i);
    return 8'(i * 7 + 3);
  endfunction

  initial for (int i = 0; i < REGS; i++) mem[i] = init_v(i);
  always @(posedge clk) if (rf_wr) begin mem[rf_addr] <= rf_wdata; wcnt <= wcnt + 1; end
  assign rf_rdata = mem[rf_addr];

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sda_m = b; wt(4); scl_m = 1'b1; wt(4); r = line; wt(4); scl_m = 1'b0; wt(4);
  endtask

  task automatic do_start;
    sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(4); sda_m = 1'b0; wt(4); scl_m = 1'b0; wt(4);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; wt(4); scl_m = 1'b1; wt(4); sda_m = 1'b1; wt(4);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, r); d[i] = r; end
    bit_x(~mack, r);
  endtask

  task automatic reg_wr(input logic [15:0] a, input logic [7:0] d, output logic ok);
    logic k0, k1, k2, k3;
    do_start; wr_byte(8'hDE, k0); wr_byte(a[15:8], k1); wr_byte(a[7:0], k2);
    wr_byte(d, k3); do_stop;
    ok = k0 & k1 & k2 & k3;
  endtask

  task automatic rand_rd(input logic [15:0] a, output logic [7:0] d);
    logic k;
    do_start; wr_byte(8'hDE, k); wr_byte(a[15:8], k); wr_byte(a[7:0], k);
    do_start; wr_byte(8'hDF, k); rd_byte(1'b0, d); do_stop;
  endtask

  task automatic cur_rd(output logic ack, output logic [7:0] d);
    do_start; wr_byte(8'hDF, ack); rd_byte(1'b0, d); do_stop;
  endtask

  task automatic t_reset;
    check("R1 SDA released in reset", {15'd0, sda_oe}, 16'd0);
    check("R9 no write strobe in reset", {15'd0, rf_wr}, 16'd0);
  endtask

  task automatic t_powerup_read;
    logic ack; logic [7:0] d;
    cur_rd(ack, d);
    check("R1 read address acknowledged", {15'd0, ack}, 16'd1);
    check("R3 current read starts at register 0", {8'd0, d}, {8'd0, init_v(0)});
  endtask

  task automatic t_bad_address;
    logic ack;
    do_start; wr_byte(8'hA0, ack); do_stop;
    check("R1 foreign address not acknowledged", {15'd0, ack}, 16'd0);
  endtask

  task automatic t_locked_write;
    logic ok; logic [7:0] d;
    reg_wr(16'h0005, 8'h5A, ok); wt(WCYC + 20);
    check("R2 all write bytes acknowledged", {15'd0, ok}, 16'd1);
    check("R6 locked write produces no strobe", 16'(wcnt), 16'd0);
    rand_rd(16'h0005, d);
    check("R4 random read of untouched register", {8'd0, d}, {8'd0, init_v(5)});
  endtask

  task automatic t_unlock_write;
    logic ok, k; logic [7:0] d;
    reg_wr(16'h003F, 8'h02, ok); wt(WCYC + 20);
    reg_wr(16'h003F, 8'h06, ok); wt(WCYC + 20);
    check("R6 status writes always taken", 16'(wcnt), 16'd2);
    do_start; wr_byte(8'hDE, k); wr_byte(8'h00, k); wr_byte(8'h05, k); wr_byte(8'h5A, k);
    check("R9 no write before stop", 16'(wcnt), 16'd2);
    do_stop; wt(6);
    check("R9 write strobe after stop", 16'(wcnt), 16'd3);
    wt(WCYC + 20);
    reg_wr(16'h1207, 8'hC3, ok); wt(WCYC + 20);
    rand_rd(16'h0007, d);
    check("R2 high word-address bits ignored", {8'd0, d}, 16'h00C3);
    rand_rd(16'h0005, d);
    check("R6 unlocked write takes effect", {8'd0, d}, 16'h005A);
  endtask

  task automatic t_busy;
    logic ok, ack; logic [7:0] d;
    reg_wr(16'h0009, 8'h11, ok);
    do_start; wr_byte(8'hDE, ack); do_stop;
    check("R7 no acknowledge during write cycle", {15'd0, ack}, 16'd0);
    wt(WCYC + 20);
    cur_rd(ack, d);
    check("R7 answers again after write cycle", {15'd0, ack}, 16'd1);
    check("R5 pointer advanced past written byte", {8'd0, d}, {8'd0, init_v(10)});
  endtask

  task automatic t_seq_read;
    logic k, ack; logic [7:0] d0, d1, d2, d3;
    do_start; wr_byte(8'hDE, k); wr_byte(8'h00, k); wr_byte(8'h3E, k);
    do_start; wr_byte(8'hDF, k);
    rd_byte(1'b1, d0); rd_byte(1'b1, d1); rd_byte(1'b0, d2); do_stop;
    check("R5 sequential byte 0", {8'd0, d0}, {8'd0, init_v(62)});
    check("R5 sequential byte 1", {8'd0, d1}, 16'h0006);
    check("R5 sequential read wraps to 0", {8'd0, d2}, {8'd0, init_v(0)});
    cur_rd(ack, d3);
    check("R5 read stopped at NACK", {8'd0, d3}, {8'd0, init_v(1)});
  endtask

  task automatic t_abort;
    logic k, r, ack; logic [7:0] d;
    do_start; wr_byte(8'hDE, k); wr_byte(8'h00, k); wr_byte(8'h05, k);
    bit_x(1'b1, r); bit_x(1'b1, r); bit_x(1'b1, r); do_stop; wt(6);
    check("R8 stop inside data byte writes nothing", 16'(wcnt), 16'd5);
    do_start; bit_x(1'b0, r); bit_x(1'b1, r); bit_x(1'b1, r); bit_x(1'b0, r);
    do_start; wr_byte(8'hDE, ack); do_stop;
    check("R8 start inside byte restarts address match", {15'd0, ack}, 16'd1);
    rand_rd(16'h0005, d);
    check("R8 aborted write left register intact", {8'd0, d}, 16'h005A);
    do_start; bit_x(1'b1, r); bit_x(1'b0, r); do_stop;
    cur_rd(ack, d);
    check("R8 answers after mid-byte stop", {15'd0, ack}, 16'd1);
  endtask

  task automatic t_relock;
    logic ok; logic [7:0] d;
    reg_wr(16'h003F, 8'h02, ok); wt(WCYC + 20);
    reg_wr(16'h003F, 8'h07, ok); wt(WCYC + 20);
    reg_wr(16'h0005, 8'h77, ok); wt(WCYC + 20);
    check("R6 wrong key locks again", 16'(wcnt), 16'd7);
    rand_rd(16'h0005, d);
    check("R6 relocked register unchanged", {8'd0, d}, 16'h005A);
  endtask

  initial begin
    wt(5);
    t_reset;
    rst_n = 1'b1;
    wt(10);
    t_powerup_read;
    t_bad_address;
    t_locked_write;
    t_unlock_write;
    t_busy;
    t_seq_read;
    t_abort;
    t_relock;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nrun++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end
endmodule